// File: doc/BRIEF.md
# Power-Mode and Reset Control Register

This block is a single 32-bit control and status word that sits inside a processor's clock and power-management unit. Software writes it through a one-cycle full-word write port and reads it back at any time. The word carries a sticky timer-event flag, a system-clock source select, a two-bit operating-mode field and three enable bits. The enables arm a reset on loss of lock, a reset on checkstop, and a bus pull-down that applies during the deeper low-power states.

The register protects itself against unsafe writes. Software cannot enter a low-power mode while a timer event is still pending. Once the core has left normal mode, the mode field is locked against software, and only a reset or an asynchronous interrupt brings it back to normal. A checkstop becomes a debug-entry request, a hard-reset request, or no action, depending on the debug checkstop enable input and the stored checkstop-reset enable. A rising loss-of-lock indication can also request a hard reset. Both requests are one-cycle registered pulses.

Top module: `pmctl_top`

## Requirements
- R1: The timer-event flag (data bit 12) is set in the cycle after any of the `tmr_irq` lines is high. Writing 1 to bit 12 clears it. Writing 0 to bit 12 leaves it unchanged.
- R2: If a timer event and a write-1-to-clear of the flag fall in the same cycle, the flag stays set.
- R3: While the timer-event flag is set, a write that requests a non-zero mode is ignored and the mode stays 00.
- R4: The mode field is data bits 9:8 and appears on `mode_o`, encoded as 00 normal, 01 doze, 10 sleep, 11 deep-sleep. A write takes effect only while the mode is 00. In any other mode, writes leave the field unchanged.
- R5: An `async_irq` pulse returns the mode to 00 in the next cycle. This takes priority over a write in the same cycle.
- R6: Data bit 10 is the clock-source select and drives `clksel_o` (0 selects the high divider, 1 the low divider). It is freely writable.
- R7: A rising edge on `lol` while the loss-of-lock enable (bit 6) is 1 gives a one-cycle `hreset_req` pulse in the following cycle. While the enable is 0, no pulse is produced.
- R8: A rising edge on `chkstop` gives a one-cycle `dbg_req` pulse in the following cycle if `dbg_chk_en` is 1. If `dbg_chk_en` is 0 and the checkstop-reset enable (bit 7) is 1, it gives a one-cycle `hreset_req` pulse instead. If both are 0, neither output pulses.
- R9: `pulldn_o` is 1 exactly when the pull-down enable (bit 5) is 1 and the mode is 10 or 11.
- R10: All data bits other than 12, 10, 9, 8, 7, 6 and 5 read as zero, whatever is written to them.
- R11: A synchronous reset clears every field and both request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| wr_en | input | 1 | Full-word write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Register read-back |
| tmr_irq | input | NUM_TMR | Timer event pulses (real-time clock, periodic, timebase, decrementer) |
| async_irq | input | 1 | Asynchronous interrupt; wakes the mode to normal |
| chkstop | input | 1 | Checkstop indication |
| dbg_chk_en | input | 1 | Debug checkstop enable from the debug unit |
| lol | input | 1 | Loss-of-lock indication |
| mode_o | output | 2 | Current operating mode |
| clksel_o | output | 1 | System clock source select |
| pulldn_o | output | 1 | Address/data bus pull-down enable |
| hreset_req | output | 1 | One-cycle hard-reset request |
| dbg_req | output | 1 | One-cycle debug-entry request |

## Verification
The bench targets several collisions. One is a timer event landing in the same cycle as a clear: a design that lets the clear win would lose the event. Another is a low-power request made while the flag is set: a design missing the guard would sleep with an interrupt pending. The bench also writes in doze mode and sends a wake interrupt together with a write. A design that does not lock the field, or that gives the write priority, would strand the core or ignore the wake. The checkstop table is covered with the debug enable both high and low, to catch a design that issues reset and debug entry together. Level-held `lol` and `chkstop` inputs expose a design that emits a level instead of a single pulse.

// File: rtl/pmctl_pkg.sv
package pmctl_pkg;
  localparam int REG_W = 32;

  // Big-endian field numbering: field bit n lives at data index REG_W-1-n.
  function automatic int be_pos(input int n);
    return REG_W - 1 - n;
  endfunction

  localparam int POS_TFLAG  = be_pos(19);
  localparam int POS_CLKSEL = be_pos(21);
  localparam int POS_MODE_H = be_pos(22);
  localparam int POS_MODE_L = be_pos(23);
  localparam int POS_CSREN  = be_pos(24);
  localparam int POS_LOLEN  = be_pos(25);
  localparam int POS_PDEN   = be_pos(26);

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_DOZE   = 2'b01,
    MODE_SLEEP  = 2'b10,
    MODE_DEEP   = 2'b11
  } pm_mode_e;
endpackage

// File: rtl/pmctl_field.sv
module pmctl_field
  import pmctl_pkg::*;
#(
  parameter int NUM_TMR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wdata,
  input  logic [NUM_TMR-1:0] tmr_irq,
  input  logic               async_irq,
  output logic               tflag,
  output pm_mode_e           mode,
  output logic               clksel,
  output logic               csr_en,
  output logic               lol_en,
  output logic               pd_en
);
  logic     any_tmr;
  logic     clr_req;
  pm_mode_e mode_wr;

  assign any_tmr = |tmr_irq;
  assign clr_req = wr_en & wdata[POS_TFLAG];
  assign mode_wr = pm_mode_e'(wdata[POS_MODE_H:POS_MODE_L]);

  // Sticky flag: a new event beats a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) tflag <= 1'b0;
    else     tflag <= (tflag & ~clr_req) | any_tmr;
  end

  // Mode field: wake first, then writes only from normal with no pending event.
  always_ff @(posedge clk) begin
    if (rst)
      mode <= MODE_NORMAL;
    else if (async_irq)
      mode <= MODE_NORMAL;
    else if (wr_en && mode == MODE_NORMAL && !tflag)
      mode <= mode_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clksel <= 1'b0;
      csr_en <= 1'b0;
      lol_en <= 1'b0;
      pd_en  <= 1'b0;
    end else if (wr_en) begin
      clksel <= wdata[POS_CLKSEL];
      csr_en <= wdata[POS_CSREN];
      lol_en <= wdata[POS_LOLEN];
      pd_en  <= wdata[POS_PDEN];
    end
  end

  assert_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    (tflag && !clr_req) |=> tflag);
  assert_set_src_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(tflag) |-> $past(any_tmr));
  assert_tie_R2: assert property (@(posedge clk) disable iff (rst)
    any_tmr |=> tflag);
  assert_block_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == MODE_NORMAL && mode != MODE_NORMAL) |-> !$past(tflag));
  assert_lock_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) != MODE_NORMAL && mode != $past(mode))
      |-> (mode == MODE_NORMAL && $past(async_irq)));
  assert_wake_R5: assert property (@(posedge clk) disable iff (rst)
    async_irq |=> mode == MODE_NORMAL);
endmodule

// File: rtl/pmctl_event.sv
module pmctl_event (
  input  logic clk,
  input  logic rst,
  input  logic lol,
  input  logic chkstop,
  input  logic dbg_chk_en,
  input  logic csr_en,
  input  logic lol_en,
  output logic hreset_req,
  output logic dbg_req
);
  logic lol_q, chk_q;
  logic lol_rise, chk_rise;

  assign lol_rise = lol & ~lol_q;
  assign chk_rise = chkstop & ~chk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lol_q       <= 1'b0;
      chk_q       <= 1'b0;
      hreset_req  <= 1'b0;
      dbg_req     <= 1'b0;
    end else begin
      lol_q       <= lol;
      chk_q       <= chkstop;
      // Debug enable overrides the checkstop reset.
      hreset_req  <= (lol_rise & lol_en) | (chk_rise & ~dbg_chk_en & csr_en);
      dbg_req     <= chk_rise & dbg_chk_en;
    end
  end

  assert_hr_cause_R7: assert property (@(posedge clk) disable iff (rst)
    hreset_req |-> ($past(lol) && $past(lol_en)) || ($past(chkstop) && $past(csr_en)));
  assert_dbg_cause_R8: assert property (@(posedge clk) disable iff (rst)
    dbg_req |-> ($past(chkstop) && $past(dbg_chk_en)));
  assert_dbg_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    dbg_req |=> !dbg_req);
  assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
    (dbg_req && hreset_req) |-> $past(lol));
endmodule

// File: rtl/pmctl_top.sv
module pmctl_top
  import pmctl_pkg::*;
#(
  parameter int NUM_TMR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [NUM_TMR-1:0] tmr_irq,
  input  logic               async_irq,
  input  logic               chkstop,
  input  logic               dbg_chk_en,
  input  logic               lol,
  output logic [1:0]         mode_o,
  output logic               clksel_o,
  output logic               pulldn_o,
  output logic               hreset_req,
  output logic               dbg_req
);
  logic     tflag, clksel, csr_en, lol_en, pd_en;
  pm_mode_e mode;

  pmctl_field #(.NUM_TMR(NUM_TMR)) u_field (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .tmr_irq   (tmr_irq),
    .async_irq (async_irq),
    .tflag     (tflag),
    .mode      (mode),
    .clksel    (clksel),
    .csr_en    (csr_en),
    .lol_en    (lol_en),
    .pd_en     (pd_en)
  );

  pmctl_event u_event (
    .clk        (clk),
    .rst        (rst),
    .lol        (lol),
    .chkstop    (chkstop),
    .dbg_chk_en (dbg_chk_en),
    .csr_en     (csr_en),
    .lol_en     (lol_en),
    .hreset_req (hreset_req),
    .dbg_req    (dbg_req)
  );

  always_comb begin
    rdata                         = '0;
    rdata[POS_TFLAG]              = tflag;
    rdata[POS_CLKSEL]             = clksel;
    rdata[POS_MODE_H:POS_MODE_L]  = mode;
    rdata[POS_CSREN]              = csr_en;
    rdata[POS_LOLEN]              = lol_en;
    rdata[POS_PDEN]               = pd_en;
  end

  assign mode_o   = mode;
  assign clksel_o = clksel;
  assign pulldn_o = pd_en & (mode == MODE_SLEEP || mode == MODE_DEEP);

  assert_pd_mode_R9: assert property (@(posedge clk) disable iff (rst)
    pulldn_o |-> mode_o[1]);
endmodule

// File: tb/sim_pmctl_top.sv
`timescale 1ns/1ps
module sim_pmctl_top;
  localparam int NT = 4;
  localparam logic [31:0] MASK = 32'h0000_17E0;

  logic clk = 1'b0;
  logic rst;
  logic wr_en;
  logic [31:0] wdata, rdata;
  logic [NT-1:0] tmr_irq;
  logic async_irq, chkstop, dbg_chk_en, lol;
  logic [1:0] mode_o;
  logic clksel_o, pulldn_o, hreset_req, dbg_req;

  int n_chk = 0, n_bad = 0;

  // Reference state
  logic m_tf, m_cs, m_csr, m_le, m_pd, m_llq, m_cq, m_hr, m_dr;
  logic [1:0] m_md;

  always #2.5 clk = ~clk;

  pmctl_top #(.NUM_TMR(NT)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .tmr_irq(tmr_irq), .async_irq(async_irq), .chkstop(chkstop),
    .dbg_chk_en(dbg_chk_en), .lol(lol), .mode_o(mode_o), .clksel_o(clksel_o),
    .pulldn_o(pulldn_o), .hreset_req(hreset_req), .dbg_req(dbg_req)
  );

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[12] = m_tf; w[10] = m_cs; w[9:8] = m_md;
    w[7] = m_csr; w[6] = m_le; w[5] = m_pd;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 flag",      {31'b0, rdata[12]}, {31'b0, m_tf});
    chk("R4 mode",      {30'b0, mode_o}, {30'b0, m_md});
    chk("R4 mode rd",   {30'b0, rdata[9:8]}, {30'b0, m_md});
    chk("R6 clksel",    {31'b0, clksel_o}, {31'b0, m_cs});
    chk("R7 hreset",    {31'b0, hreset_req}, {31'b0, m_hr});
    chk("R8 dbg",       {31'b0, dbg_req}, {31'b0, m_dr});
    chk("R9 pulldn",    {31'b0, pulldn_o}, {31'b0, m_pd & m_md[1]});
    chk("R10 word",     rdata, exp_word());
  endtask

  task automatic step(input logic w, input logic [31:0] d, input logic [NT-1:0] ti,
                      input logic ai, input logic c, input logic de, input logic ll);
    logic n_tf;
    logic [1:0] n_md;
    check_all();
    wr_en = w; wdata = d; tmr_irq = ti; async_irq = ai;
    chkstop = c; dbg_chk_en = de; lol = ll;
    n_tf = (m_tf & ~(w & d[12])) | (|ti);
    if (ai) n_md = 2'b00;
    else if (w && m_md == 2'b00 && !m_tf) n_md = d[9:8];
    else n_md = m_md;
    m_hr = (ll & ~m_llq & m_le) | (c & ~m_cq & ~de & m_csr);
    m_dr = c & ~m_cq & de;
    m_llq = ll; m_cq = c;
    if (w) begin m_cs = d[10]; m_csr = d[7]; m_le = d[6]; m_pd = d[5]; end
    m_tf = n_tf; m_md = n_md;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    {m_tf, m_cs, m_csr, m_le, m_pd, m_llq, m_cq, m_hr, m_dr} = '0;
    m_md = 2'b00;
    rst = 1'b1; wr_en = 0; wdata = '0; tmr_irq = '0;
    async_irq = 0; chkstop = 0; dbg_chk_en = 0; lol = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11 rdata", rdata, 32'h0);
    chk("R11 req", {30'b0, hreset_req, dbg_req}, 32'h0);

    step(1, 32'h0000_0100, 0, 0, 0, 0, 0);   // enter doze
    chk("R4 enter doze", {30'b0, mode_o}, 32'd1);
    step(1, 32'h0000_0300, 0, 0, 0, 0, 0);   // locked
    chk("R4 locked", {30'b0, mode_o}, 32'd1);
    step(0, 32'h0, 0, 1, 0, 0, 0);           // wake
    chk("R5 wake", {30'b0, mode_o}, 32'd0);
    step(0, 32'h0, 4'b0100, 0, 0, 0, 0);     // timebase event
    chk("R1 set", {31'b0, rdata[12]}, 32'd1);
    step(1, 32'h0000_0200, 0, 0, 0, 0, 0);   // sleep blocked
    chk("R3 blocked", {30'b0, mode_o}, 32'd0);
    step(1, 32'h0, 0, 0, 0, 0, 0);           // write 0 keeps flag
    chk("R1 w0", {31'b0, rdata[12]}, 32'd1);
    step(1, 32'h0000_1000, 4'b0001, 0, 0, 0, 0);
    chk("R2 tie", {31'b0, rdata[12]}, 32'd1);
    step(1, 32'h0000_1000, 0, 0, 0, 0, 0);
    chk("R1 clear", {31'b0, rdata[12]}, 32'd0);
    step(1, 32'h0000_0300, 0, 1, 0, 0, 0);   // wake beats write
    chk("R5 priority", {30'b0, mode_o}, 32'd0);
    step(1, 32'hFFFF_EFFF, 0, 0, 0, 0, 0);   // all bits, flag untouched
    chk("R10 reserved", rdata & ~MASK, 32'h0);
    chk("R9 pd deep", {31'b0, pulldn_o}, 32'd1);
    chk("R6 low sel", {31'b0, clksel_o}, 32'd1);
    step(0, 32'h0, 0, 0, 0, 0, 1);
    chk("R7 pulse", {31'b0, hreset_req}, 32'd1);
    step(0, 32'h0, 0, 0, 0, 0, 1);
    chk("R7 single", {31'b0, hreset_req}, 32'd0);
    step(0, 32'h0, 0, 0, 1, 0, 0);
    chk("R8 reset", {30'b0, hreset_req, dbg_req}, 32'd2);
    step(0, 32'h0, 0, 0, 0, 0, 0);
    step(0, 32'h0, 0, 0, 1, 1, 0);
    chk("R8 debug", {30'b0, hreset_req, dbg_req}, 32'd1);
    step(1, 32'h0, 0, 1, 0, 0, 0);           // wake, clear enables
    step(0, 32'h0, 0, 0, 1, 0, 0);
    chk("R8 none", {30'b0, hreset_req, dbg_req}, 32'd0);

    for (int i = 0; i < 4000; i++) begin
      logic w, ai, c, de, ll;
      logic [NT-1:0] ti;
      w  = ($urandom % 3) == 0;
      ti = (($urandom % 8) == 0) ? NT'($urandom) : '0;
      ai = ($urandom % 12) == 0;
      c  = ($urandom % 4) == 0;
      de = $urandom % 2;
      ll = ($urandom % 4) == 0;
      step(w, $urandom, ti, ai, c, de, ll);
    end
    check_all();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule